// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by reading a two-level page table held in memory. A walk starts from the table base value presented on `ptbr`. The top ten bits of the virtual address select a word in the first-level table. That word gives the base of a second-level table. The next ten bits select a word there, and that word gives the physical frame. The frame is joined to the unchanged 12-bit page offset.

Every table word is 32 bits wide. Bit 0 is its valid flag and bits 31:12 hold a 4 KB-aligned base. A word is found at base plus index times four. The walker makes its reads one at a time on a simple memory port. It holds a request until the memory acknowledges it, then waits for the data, which arrives with `mem_rvalid` in a later cycle. A cleared valid flag at either level ends the walk with a page fault instead of an address.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1 and `resp_done`, `resp_fault` and `mem_req` are 0.
- R2: The first read of a walk goes to {ptbr[31:12], vaddr[31:22], 2'b00}.
- R3: After a valid first-level word E1, the second read goes to {E1[31:12], vaddr[21:12], 2'b00}.
- R4: After a valid second-level word E2, the walk ends with `resp_done`=1, `resp_fault`=0 and `resp_paddr` = {E2[31:12], vaddr[11:0]}.
- R5: A first-level word with bit 0 = 0 ends the walk with `resp_done`=1 and `resp_fault`=1. No second read is issued, and `resp_paddr` is 0.
- R6: A second-level word with bit 0 = 0 ends the walk with `resp_done`=1, `resp_fault`=1 and `resp_paddr`=0.
- R7: `resp_done` is high for exactly one cycle per walk, and `resp_fault` is never high without `resp_done`.
- R8: `mem_req` stays high with a stable `mem_addr` until `mem_ack` is sampled high.
- R9: `ptbr` is sampled when a walk starts. Later changes do not affect that walk.
- R10: A request is accepted only while `req_ready` is 1. `req_ready` stays 0 from acceptance until the cycle after `resp_done`. `req_vaddr` changes during a walk are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptbr | input | 32 | First-level table base; bits 31:12 are used |
| req_valid | input | 1 | Translate request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle and able to accept |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_fault | output | 1 | Page fault, valid with resp_done |
| resp_paddr | output | 32 | Physical address, valid with resp_done |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Word address of the read |
| mem_ack | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench uses invalid words at each level. A walker that ignored the first-level valid flag would issue a second read from a garbage base, and one that ignored the second-level flag would return a bogus address without a fault. It delays `mem_ack` for several cycles to catch a walker that drops its request or moves its address before acceptance. It changes `ptbr` and `req_vaddr` in the middle of a walk. A walker that read these live would produce the wrong table addresses, and one that accepted the second request early would run a second, unexpected walk.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ptbr,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  output logic        req_ready,
  output logic        resp_done,
  output logic        resp_fault,
  output logic [31:0] resp_paddr,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  localparam int AW = 2 * IDX_W + OFF_W;
  localparam int BW = AW - OFF_W;

  typedef enum logic [2:0] {IDLE, READ_L1, WAIT_L1, READ_L2, WAIT_L2, DONE} state_t;

  state_t          state;
  logic [AW-1:0]   va_q;
  logic [BW-1:0]   base_q;
  logic [AW-1:0]   paddr_q;
  logic            fault_q;

  wire [IDX_W-1:0] idx = (state == READ_L1) ? va_q[AW-1 -: IDX_W] : va_q[OFF_W+IDX_W-1 -: IDX_W];

  assign req_ready  = (state == IDLE);
  assign resp_done  = (state == DONE);
  assign resp_fault = resp_done & fault_q;
  assign resp_paddr = resp_done ? paddr_q : '0;
  assign mem_req    = (state == READ_L1) || (state == READ_L2);
  assign mem_addr   = {base_q, idx, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= IDLE;
      va_q    <= '0;
      base_q  <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else begin
      case (state)
        IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          base_q  <= ptbr[AW-1:OFF_W];
          fault_q <= 1'b0;
          paddr_q <= '0;
          state   <= READ_L1;
        end
        READ_L1: if (mem_ack) state <= WAIT_L1;
        WAIT_L1: if (mem_rvalid) begin
          if (mem_rdata[0]) begin
            base_q <= mem_rdata[AW-1:OFF_W];
            state  <= READ_L2;
          end else begin
            fault_q <= 1'b1;
            state   <= DONE;
          end
        end
        READ_L2: if (mem_ack) state <= WAIT_L2;
        WAIT_L2: if (mem_rvalid) begin
          if (mem_rdata[0]) paddr_q <= {mem_rdata[AW-1:OFF_W], va_q[OFF_W-1:0]};
          else              fault_q <= 1'b1;
          state <= DONE;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        resp_done,
  input logic        resp_fault,
  input logic [31:0] resp_paddr,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [31:0] mem_addr
);
  AST_FAULT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) resp_fault |-> resp_done); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) resp_done |=> !resp_done); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R8
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) req_ready && req_valid |=> !req_ready); // R10
  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) resp_done |-> !req_ready && !mem_req); // R10
  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n) resp_fault |-> resp_paddr == 32'h0); // R5
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_done(resp_done), .resp_fault(resp_fault), .resp_paddr(resp_paddr),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] ptbr = 0;
  logic        req_valid = 0;
  logic [31:0] req_vaddr = 0;
  logic        req_ready, resp_done, resp_fault, mem_req;
  logic [31:0] resp_paddr, mem_addr;
  logic        mem_ack = 0, mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] mem [int unsigned];
  logic [31:0] seen [$];
  int ack_delay = 0, wait_cnt = 0;
  bit pending = 0, addr_moved = 0, req_prev = 0;
  logic [31:0] addr_prev = 0, pend_addr = 0;

  always #2.5 clk = ~clk;

  pt_walker u_dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (req_prev && mem_req && mem_addr != addr_prev && !mem_ack) addr_moved = 1;
    req_prev  = mem_req && !mem_ack;
    addr_prev = mem_addr;
    mem_ack    <= 0;
    mem_rvalid <= 0;
    if (pending) begin
      mem_rvalid <= 1;
      mem_rdata  <= mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
      pending = 0;
    end else if (mem_req && !mem_ack) begin
      if (wait_cnt >= ack_delay) begin
        mem_ack <= 1;
        pending = 1;
        pend_addr = mem_addr;
        seen.push_back(mem_addr);
        wait_cnt = 0;
      end else wait_cnt++;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Runs one walk; hold keeps req_valid high with a new vaddr, newptbr changes ptbr mid-walk
  task automatic walk(logic [31:0] va, bit hold, logic [31:0] alt_va, bit chg_ptbr, logic [31:0] new_ptbr,
                      output logic fault, output logic [31:0] pa);
    int n = 0;
    seen.delete();
    addr_moved = 0;
    @(negedge clk);
    req_valid = 1; req_vaddr = va;
    @(negedge clk);
    chk("R10 busy after accept", req_ready, 0);
    if (hold) req_vaddr = alt_va; else req_valid = 0;
    if (chg_ptbr) ptbr = new_ptbr;
    while (!resp_done && n < 60) begin @(negedge clk); n++; end
    chk("R7 done seen", resp_done, 1);
    chk("R10 not ready at done", req_ready, 0);
    fault = resp_fault; pa = resp_paddr;
    req_valid = 0;
    @(negedge clk);
    chk("R7 done one cycle", resp_done, 0);
    chk("R7 fault only with done", resp_fault, 0);
    chk("R10 ready after done", req_ready, 1);
    chk("R8 addr stable while waiting", addr_moved, 0);
  endtask

  task automatic t_reset();
    chk("R1 ready", req_ready, 1);
    chk("R1 done", resp_done, 0);
    chk("R1 fault", resp_fault, 0);
    chk("R1 mem_req", mem_req, 0);
  endtask

  task automatic t_ok(logic [31:0] pt, logic [31:0] va, logic [31:0] l2b, logic [31:0] frame, int dly);
    logic f; logic [31:0] pa;
    logic [31:0] a1 = {pt[31:12], va[31:22], 2'b00};
    logic [31:0] a2 = {l2b[31:12], va[21:12], 2'b00};
    ptbr = pt; ack_delay = dly;
    mem[a1] = {l2b[31:12], 11'h0, 1'b1};
    mem[a2] = {frame[31:12], 11'h5a5, 1'b1};
    walk(va, 0, 0, 0, 0, f, pa);
    chk("R2 L1 address", seen.size() > 0 ? seen[0] : 32'hx, a1);
    chk("R3 L2 address", seen.size() > 1 ? seen[1] : 32'hx, a2);
    chk("R4 no fault", f, 0);
    chk("R4 paddr", pa, {frame[31:12], va[11:0]});
  endtask

  task automatic t_l1_fault();
    logic f; logic [31:0] pa;
    logic [31:0] va = 32'h7FC0_1ABC;
    ptbr = 32'h0003_0000; ack_delay = 0;
    mem[{ptbr[31:12], va[31:22], 2'b00}] = 32'hABCD_E000;
    walk(va, 0, 0, 0, 0, f, pa);
    chk("R5 fault", f, 1);
    chk("R5 paddr zero", pa, 0);
    chk("R5 single read", seen.size(), 1);
  endtask

  task automatic t_l2_fault();
    logic f; logic [31:0] pa;
    logic [31:0] va = 32'h0080_2FFF;
    ptbr = 32'h0004_0000; ack_delay = 1;
    mem[{ptbr[31:12], va[31:22], 2'b00}] = 32'h0005_0001;
    mem[{20'h00050, va[21:12], 2'b00}] = 32'h1234_5FFE;
    walk(va, 0, 0, 0, 0, f, pa);
    chk("R6 fault", f, 1);
    chk("R6 paddr zero", pa, 0);
    chk("R6 two reads", seen.size(), 2);
  endtask

  task automatic t_ptbr_change();
    logic f; logic [31:0] pa;
    logic [31:0] va = 32'h0040_3123;
    ptbr = 32'h0006_0000; ack_delay = 2;
    mem[{20'h00060, va[31:22], 2'b00}] = 32'h0007_0001;
    mem[{20'h00070, va[21:12], 2'b00}] = 32'h0ABC_D001;
    walk(va, 0, 0, 1, 32'h0009_0000, f, pa);
    chk("R9 L1 from sampled ptbr", seen.size() > 0 ? seen[0] : 32'hx, {20'h00060, va[31:22], 2'b00});
    chk("R9 paddr", pa, 32'h0ABC_D123);
  endtask

  task automatic t_busy_ignore();
    logic f; logic [31:0] pa;
    logic [31:0] va = 32'hC030_0456;
    ptbr = 32'h000A_0000; ack_delay = 0;
    mem[{20'h000A0, va[31:22], 2'b00}] = 32'h000B_0001;
    mem[{20'h000B0, va[21:12], 2'b00}] = 32'h5555_5001;
    walk(va, 1, 32'h0000_0000, 0, 0, f, pa);
    chk("R10 vaddr change ignored", pa, 32'h5555_5456);
    chk("R10 only one walk", seen.size(), 2);
    repeat (3) @(negedge clk);
    chk("R10 no extra walk", mem_req | resp_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ok(32'h0001_0000, 32'h1234_5678, 32'h0002_0000, 32'h8765_4000, 0);
    t_ok(32'hFFFF_F000, 32'hFFFF_FFFF, 32'hFFFF_E000, 32'hFFFF_F000, 3);
    t_ok(32'h0010_0ABC, 32'h0000_0000, 32'h0011_0000, 32'h0000_1000, 1);
    t_l1_fault();
    t_l2_fault();
    t_ptbr_change();
    t_busy_ignore();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule